// File: doc/BRIEF.md
# Star Cluster Hub with Per-Target Response Ordering

The hub sits at the centre of a star of satellite nodes. Each satellite wraps a simple bus port that allows only one transaction in flight and cannot reorder responses. It may act as an initiator, as a target, or as both. The hub takes one packet per cycle from the satellites. A request to a local target goes straight to that target's output. The hub also records the requesting port in a small queue kept for that target. When the target later sends a response, it carries no requester identity. The hub takes the oldest entry of that target's queue, writes it into the destination field and delivers the response there. In this way several initiators can share the same targets.

A request whose destination ID is not a satellite of this star leaves on the ring port as two beats. The first beat is a prefix carrying the cluster ID and the source ID. The second beat is the unchanged packet. Every packet is a single word with the layout {resp, dst, src, payload}: bit PKW-1 is the response flag, followed by a dst field of IDW bits, a src field of IDW bits and PLW payload bits at the bottom.

Top module: `star_hub`

## Requirements
- R1: While reset is asserted, no input is granted, no output or ring beat is valid, and the pending-error flag is 0.
- R2: A request (resp=0) whose dst is below N_SAT and is accepted at a clock edge appears unchanged on output port dst, valid for exactly the cycle after that edge.
- R3: A response (resp=1) accepted from port t goes to the port recorded first among the still-pending requests to t. It is delivered the cycle after acceptance, with dst replaced by that port and src and payload unchanged.
- R4: Each target keeps its own pending queue. A response from one target never consumes an entry recorded for another target.
- R5: A request to a target that already has DEPTH pending entries is not granted: in_ready stays 0 and nothing is delivered. Requests to other targets are still granted.
- R6: A response from a target with no pending entry is dropped, so no output is valid. It sets pend_err, which stays 1 until reset.
- R7: Among simultaneously eligible inputs, the grant goes to the first one at or after a rotating pointer. The pointer moves to the granted index plus one, wrapping at N_SAT, and is 0 after reset.
- R8: A request whose dst is N_SAT or above produces two ring beats on consecutive cycles. The first beat has ring_sop=1 and the word {0, CLUSTER_ID, src, zero payload}. The second beat has ring_sop=0 and the original packet.
- R9: In the cycle in which a ring packet's second beat is pending, no ring-bound request is granted, but local traffic is.
- R10: At most one input is granted per cycle, and only an input that presents valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | N_SAT | Packet present, one bit per satellite |
| in_pkt | input | N_SAT*PKW | Incoming packets, satellite i at bits i*PKW upward |
| in_ready | output | N_SAT | Packet taken at the coming edge (combinational grant) |
| out_valid | output | N_SAT | Delivered packet valid, one bit per satellite |
| out_pkt | output | N_SAT*PKW | Delivered packets, same slicing as in_pkt |
| ring_valid | output | 1 | Ring beat valid |
| ring_sop | output | 1 | Ring beat is the prefix word |
| ring_word | output | PKW | Ring beat data |
| pend_err | output | 1 | Sticky flag: a response arrived with nothing pending |

## Verification
The bench interleaves requests from several initiators to one target and then returns the responses. A hub that matched responses by the header or by the wrong end of the queue would deliver to the newest requester or to the junk dst field. It fills one queue to DEPTH and checks that a further request is refused while another target still receives traffic. An off-by-one full test would either overrun the queue or stall one entry early. A response to an empty queue must produce no output and a sticky error; a faulty hub would invent a destination or clear the flag. The round-robin case holds a lower-index satellite against a higher one right after the pointer has passed it, which exposes fixed priority. The ring case checks the prefix contents and the refusal of a back-to-back ring request.

// File: rtl/star_hub.sv
module star_hub #(
  parameter int N_SAT      = 4,
  parameter int IDW        = 3,
  parameter int PLW        = 8,
  parameter int DEPTH      = 4,
  parameter int CLUSTER_ID = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_SAT-1:0]         in_valid,
  input  logic [N_SAT*(1+2*IDW+PLW)-1:0] in_pkt,
  output logic [N_SAT-1:0]         in_ready,
  output logic [N_SAT-1:0]         out_valid,
  output logic [N_SAT*(1+2*IDW+PLW)-1:0] out_pkt,
  output logic                     ring_valid,
  output logic                     ring_sop,
  output logic [1+2*IDW+PLW-1:0]   ring_word,
  output logic                     pend_err
);
  localparam int PKW = 1 + 2*IDW + PLW;
  localparam int SW  = (N_SAT > 1) ? $clog2(N_SAT) : 1;
  localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW  = $clog2(DEPTH + 1);

  logic [PKW-1:0]   pk   [N_SAT];
  logic [PKW-1:0]   oq   [N_SAT];
  logic [IDW-1:0]   mem  [N_SAT][DEPTH];
  logic [AW-1:0]    wp   [N_SAT];
  logic [AW-1:0]    rp   [N_SAT];
  logic [CW-1:0]    cnt  [N_SAT];
  logic [N_SAT-1:0] full, elig;
  logic [SW-1:0]    ptr, win;
  logic             any, ring_pend;
  logic [PKW-1:0]   hold, a_pkt;

  function automatic logic is_loc(input logic [IDW-1:0] d);
    return int'(d) < N_SAT;
  endfunction

  for (genvar g = 0; g < N_SAT; g++) begin : g_port
    assign pk[g] = in_pkt[g*PKW +: PKW];
    assign out_pkt[g*PKW +: PKW] = oq[g];
    assign full[g] = (cnt[g] == CW'(DEPTH));
  end

  always_comb begin
    for (int i = 0; i < N_SAT; i++) begin
      logic blk;
      logic [IDW-1:0] d;
      d   = pk[i][PKW-2 -: IDW];
      blk = ring_pend;
      if (is_loc(d)) begin
        blk = 1'b0;
        for (int j = 0; j < N_SAT; j++)
          if (int'(d) == j) blk = full[j];
      end
      elig[i] = rst_n & in_valid[i] & (pk[i][PKW-1] | ~blk);
    end
  end

  always_comb begin
    any = 1'b0;
    win = '0;
    for (int k = 0; k < N_SAT; k++) begin
      int idx;
      idx = (int'(ptr) + k) % N_SAT;
      if (!any && elig[idx]) begin
        any = 1'b1;
        win = SW'(idx);
      end
    end
  end

  assign in_ready = any ? (N_SAT'(1) << win) : '0;
  assign a_pkt = pk[win];

  wire             a_resp = a_pkt[PKW-1];
  wire [IDW-1:0]   a_dst  = a_pkt[PKW-2 -: IDW];
  wire [IDW-1:0]   a_src  = a_pkt[PKW-2-IDW -: IDW];
  wire [PLW-1:0]   a_pay  = a_pkt[PLW-1:0];
  wire [SW-1:0]    a_ds   = a_dst[SW-1:0];
  wire [IDW-1:0]   head   = mem[win][rp[win]];
  wire             do_req = any & ~a_resp & is_loc(a_dst);

  always_ff @(posedge clk) begin
    if (do_req) mem[a_ds][wp[a_ds]] <= IDW'(win);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr        <= '0;
      ring_valid <= 1'b0;
      ring_sop   <= 1'b0;
      ring_word  <= '0;
      ring_pend  <= 1'b0;
      hold       <= '0;
      pend_err   <= 1'b0;
      out_valid  <= '0;
      for (int i = 0; i < N_SAT; i++) begin
        oq[i]  <= '0;
        wp[i]  <= '0;
        rp[i]  <= '0;
        cnt[i] <= '0;
      end
    end else begin
      out_valid  <= '0;
      ring_valid <= ring_pend;
      ring_sop   <= 1'b0;
      ring_pend  <= 1'b0;
      if (ring_pend) ring_word <= hold;
      if (any) begin
        ptr <= (win == SW'(N_SAT-1)) ? '0 : win + SW'(1);
        if (a_resp) begin
          if (cnt[win] != '0) begin
            out_valid[head[SW-1:0]] <= 1'b1;
            oq[head[SW-1:0]]        <= {1'b1, head, a_src, a_pay};
            rp[win]                 <= rp[win] + AW'(1);
            cnt[win]                <= cnt[win] - CW'(1);
          end else begin
            pend_err <= 1'b1;
          end
        end else if (is_loc(a_dst)) begin
          wp[a_ds]        <= wp[a_ds] + AW'(1);
          cnt[a_ds]       <= cnt[a_ds] + CW'(1);
          out_valid[a_ds] <= 1'b1;
          oq[a_ds]        <= a_pkt;
        end else begin
          ring_valid <= 1'b1;
          ring_sop   <= 1'b1;
          ring_word  <= {1'b0, IDW'(CLUSTER_ID), a_src, PLW'(0)};
          hold       <= a_pkt;
          ring_pend  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/star_hub_chk.sv
module star_hub_chk #(
  parameter int N_SAT = 4,
  parameter int IDW   = 3,
  parameter int PLW   = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [N_SAT-1:0]         in_valid,
  input logic [N_SAT*(1+2*IDW+PLW)-1:0] in_pkt,
  input logic [N_SAT-1:0]         in_ready,
  input logic [N_SAT-1:0]         out_valid,
  input logic [N_SAT*(1+2*IDW+PLW)-1:0] out_pkt,
  input logic                     ring_valid,
  input logic                     ring_sop,
  input logic                     pend_err
);
  localparam int PKW = 1 + 2*IDW + PLW;

  assert_one_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(in_ready));

  assert_grant_needs_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready & ~in_valid) == '0);

  assert_prefix_then_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_valid && ring_sop) |=> (ring_valid && !ring_sop));

  assert_data_after_prefix_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_valid && !ring_sop) |-> $past(ring_valid && ring_sop));

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pend_err |=> pend_err);

  for (genvar g = 0; g < N_SAT; g++) begin : g_chk
    assert_out_dst_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[g] |-> (out_pkt[g*PKW + PKW-2 -: IDW] == IDW'(g)));

    assert_ring_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready[g] && !in_pkt[g*PKW + PKW-1]
        && int'(in_pkt[g*PKW + PKW-2 -: IDW]) >= N_SAT)
      |-> !(ring_valid && ring_sop));
  end
endmodule

bind star_hub star_hub_chk #(.N_SAT(N_SAT), .IDW(IDW), .PLW(PLW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pkt(in_pkt),
  .in_ready(in_ready), .out_valid(out_valid), .out_pkt(out_pkt),
  .ring_valid(ring_valid), .ring_sop(ring_sop), .pend_err(pend_err)
);

// File: tb/test_star_hub.sv
module test_star_hub;
  localparam int N  = 4;
  localparam int PW = 15;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    in_valid = '0;
  logic [N*PW-1:0] in_pkt = '0;
  logic [N-1:0]    in_ready, out_valid;
  logic [N*PW-1:0] out_pkt;
  logic            ring_valid, ring_sop, pend_err;
  logic [PW-1:0]   ring_word;

  int tests = 0;
  int fails = 0;

  logic [N-1:0]    ov;
  logic [N*PW-1:0] op;
  logic            rv, rs;
  logic [PW-1:0]   rw;

  star_hub i_star_hub (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pkt(in_pkt),
    .in_ready(in_ready), .out_valid(out_valid), .out_pkt(out_pkt),
    .ring_valid(ring_valid), .ring_sop(ring_sop), .ring_word(ring_word),
    .pend_err(pend_err)
  );

  always #10 clk = ~clk;

  // sat, resp, dst, src, payload, expected port, expected dst
  localparam logic [22:0] VEC [8] = '{
    {2'd0, 1'b0, 3'd2, 3'd0, 8'h11, 3'd2, 3'd2},
    {2'd1, 1'b0, 3'd2, 3'd1, 8'h22, 3'd2, 3'd2},
    {2'd3, 1'b0, 3'd1, 3'd3, 8'h33, 3'd1, 3'd1},
    {2'd2, 1'b1, 3'd5, 3'd2, 8'hA1, 3'd0, 3'd0},
    {2'd1, 1'b1, 3'd5, 3'd1, 8'hB1, 3'd3, 3'd3},
    {2'd2, 1'b1, 3'd5, 3'd2, 8'hA2, 3'd1, 3'd1},
    {2'd0, 1'b0, 3'd3, 3'd0, 8'h44, 3'd3, 3'd3},
    {2'd3, 1'b1, 3'd5, 3'd3, 8'hC1, 3'd0, 3'd0}
  };

  function automatic logic [PW-1:0] mk(input logic r, input logic [2:0] d,
                                       input logic [2:0] s, input logic [7:0] py);
    return {r, d, s, py};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic capture();
    ov = out_valid; op = out_pkt; rv = ring_valid; rs = ring_sop; rw = ring_word;
  endtask

  task automatic send(input int s, input logic [PW-1:0] p, output logic acc);
    @(negedge clk);
    in_valid = '0;
    in_valid[s] = 1'b1;
    in_pkt[s*PW +: PW] = p;
    #2 acc = in_ready[s];
    @(posedge clk);
    #1 capture();
    in_valid = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic acc;
    logic [N-1:0] exp_rr [4];
    logic [N-1:0] msk_rr [4];

    // R1: reset state, inputs presented during reset are not granted
    in_valid = 4'b0011;
    in_pkt[0 +: PW] = mk(0, 3'd1, 3'd0, 8'h01);
    in_pkt[PW +: PW] = mk(0, 3'd6, 3'd1, 8'h02);
    repeat (3) @(posedge clk);
    #1;
    chk("R1 ready in reset", in_ready, 0);
    chk("R1 out_valid in reset", out_valid, 0);
    chk("R1 ring_valid in reset", ring_valid, 0);
    chk("R1 pend_err in reset", pend_err, 0);
    in_valid = '0;
    @(negedge clk);
    rst_n = 1'b1;

    // R2/R3: table of single-packet vectors
    for (int v = 0; v < 8; v++) begin
      logic [22:0] e;
      string tg;
      e  = VEC[v];
      tg = e[20] ? "R3" : "R2";
      send(int'(e[22:21]), mk(e[20], e[19:17], e[16:14], e[13:6]), acc);
      chk({tg, " accept"}, acc, 1);
      chk({tg, " out port"}, ov, 4'b1 << e[5:3]);
      chk({tg, " out pkt"}, op[e[5:3]*PW +: PW], mk(e[20], e[2:0], e[16:14], e[13:6]));
    end
    chk("R6 no error yet", pend_err, 0);

    // R7/R10: round robin from reset pointer, four requests to target 0
    do_reset();
    msk_rr = '{4'b1110, 4'b1110, 4'b1010, 4'b0010};
    exp_rr = '{4'b0010, 4'b0100, 4'b1000, 4'b0010};
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      in_valid = msk_rr[c];
      for (int s = 1; s < N; s++) in_pkt[s*PW +: PW] = mk(0, 3'd0, 3'(s), 8'(8'h50 + c));
      #2;
      chk("R7 round robin grant", in_ready, exp_rr[c]);
      chk("R10 single grant", $countones(in_ready), 1);
      @(posedge clk);
      #1 capture();
      chk("R2 delivered to target 0", ov, 4'b0001);
    end
    in_valid = '0;

    // R5: queue of target 0 is full
    send(2, mk(0, 3'd0, 3'd2, 8'h60), acc);
    chk("R5 full target refused", acc, 0);
    chk("R5 nothing delivered", ov, 0);
    send(2, mk(0, 3'd3, 3'd2, 8'h61), acc);
    chk("R5 other target accepted", acc, 1);
    chk("R5 other target delivered", ov, 4'b1000);

    // R3: drain target 0 in recorded order 1,2,3,1
    for (int c = 0; c < 4; c++) begin
      int r;
      r = (c == 3) ? 1 : c + 1;
      send(0, mk(1, 3'd7, 3'd0, 8'(8'h70 + c)), acc);
      chk("R3 response accepted", acc, 1);
      chk("R3 oldest requester port", ov, 4'b1 << r);
      chk("R3 rewritten packet", op[r*PW +: PW], mk(1, 3'(r), 3'd0, 8'(8'h70 + c)));
    end

    // R6/R4: response from target 1 with nothing pending
    send(1, mk(1, 3'd2, 3'd1, 8'h80), acc);
    chk("R6 dropped response", ov, 0);
    chk("R6 error set", pend_err, 1);
    // R4: target 3 still holds requester 2
    send(3, mk(1, 3'd0, 3'd3, 8'h81), acc);
    chk("R4 separate queue port", ov, 4'b0100);
    chk("R4 separate queue pkt", op[2*PW +: PW], mk(1, 3'd2, 3'd3, 8'h81));
    chk("R6 error sticky", pend_err, 1);

    // R8/R9: ring forwarding
    @(negedge clk);
    in_valid = 4'b0010;
    in_pkt[PW +: PW] = mk(0, 3'd6, 3'd1, 8'h5A);
    #2 chk("R8 ring request granted", in_ready, 4'b0010);
    @(posedge clk);
    #1 capture();
    chk("R8 prefix beat", {rv, rs}, 2'b11);
    chk("R8 prefix word", rw, {1'b0, 3'd5, 3'd1, 8'h00});
    in_valid = 4'b1100;
    in_pkt[2*PW +: PW] = mk(0, 3'd7, 3'd2, 8'h66);
    in_pkt[3*PW +: PW] = mk(0, 3'd0, 3'd3, 8'h77);
    @(negedge clk);
    #2 chk("R9 ring blocked local granted", in_ready, 4'b1000);
    @(posedge clk);
    #1 capture();
    chk("R8 data beat", {rv, rs}, 2'b10);
    chk("R8 data word", rw, mk(0, 3'd6, 3'd1, 8'h5A));
    chk("R9 local delivered", ov, 4'b0001);
    in_valid = 4'b0100;
    @(negedge clk);
    #2 chk("R9 ring granted after", in_ready, 4'b0100);
    @(posedge clk);
    #1 capture();
    in_valid = '0;
    chk("R8 second prefix", {rv, rs, rw}, {2'b11, 1'b0, 3'd5, 3'd2, 8'h00});
    @(posedge clk);
    #1 capture();
    chk("R8 second data", {rv, rs, rw}, {2'b10, mk(0, 3'd7, 3'd2, 8'h66)});
    @(posedge clk);
    #1 chk("R8 ring idle", ring_valid, 0);

    // R1: reset clears the sticky error
    do_reset();
    #1 chk("R1 error cleared", pend_err, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule